// File: doc/BRIEF.md
# Vertical Sync Pulse Extractor

This block reads an active-low composite sync stream that an upstream slicer has already turned into a digital level. It produces a single active-low vertical sync pulse per field. Ordinary line sync and the short equalizing pulses hold the line low only briefly. In the serration phase of the vertical interval, each low run is much longer. The block measures every low run in clocks of its own sampling clock. The first rise of sync that ends a long, serration-class low run starts the vertical pulse. The falling edge of the output marks the start of the vertical period.

Some non-standard sources carry no serrations. For these, a timeout path starts the pulse once the sync input has stayed low for a programmable default delay, counted from the last falling edge. In both cases the pulse has a fixed programmable width. After a pulse starts, a hold-off window keeps the rest of the same vertical interval from starting a second pulse. A loss-of-sync flag forces the output low and clears the hold-off. All thresholds are elaboration-time clock counts. The raw sync input crosses a two-stage synchronizer before any edge is detected, so both trigger paths see the same fixed latency.

Top module: `vsync_extract`

## Requirements
- R1: While `rst_n` is low, `vsync_n` is high, and it goes high at once when reset is asserted, with no clock edge needed. After reset is released, `vsync_n` stays high as long as `csync_n` stays high.
- R2: Suppose `csync_n` is sampled low on more than `SERR_MIN` consecutive rising clock edges and is then sampled high. Suppose also that the timeout has not fired and no hold-off is running. Then `vsync_n` falls on the 3rd rising edge, counting the first edge that samples `csync_n` high as the 1st.
- R3: A low run of `SERR_MIN` samples or fewer, as in line sync or equalizing pulses, starts no vertical pulse.
- R4: Suppose `csync_n` is sampled low on `DFLT_DLY` consecutive edges while no hold-off is running. Then `vsync_n` falls on rising edge number `DFLT_DLY`+2, counting the first low-sampling edge as the 1st. This happens even though `csync_n` is still low.
- R5: Each vertical pulse that is not cut short by reset or loss of sync keeps `vsync_n` low for exactly `VS_WIDTH` clock cycles. This holds for both the serration start and the timeout start.
- R6: A trigger is ignored if it would start a pulse fewer than `HOLDOFF` clocks after the previous pulse started. A trigger that starts a pulse exactly `HOLDOFF` clocks after the previous one is accepted.
- R7: When `sync_lost` is sampled high, `vsync_n` is low from the next edge on. Triggers that occur while it is high are dropped. After it is sampled low, `vsync_n` returns high on the next edge. The hold-off is cleared, so the next valid trigger starts a pulse.
- R8: A single unbroken low run starts at most one pulse, even when it lasts far past `DFLT_DLY` and ends with a serration-class rise.
- R9: A standard vertical interval starts exactly one pulse, at the first serration rise. In this pattern, short-low equalizing pulses come before and after a string of long-low serration pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock; all timing parameters count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| csync_n | input | 1 | Sliced composite sync, active low, asynchronous to `clk` |
| sync_lost | input | 1 | Loss-of-sync flag, synchronous to `clk`, active high |
| vsync_n | output | 1 | Vertical sync pulse, active low, registered |

## Verification
The assertions assume that `sync_lost` is synchronous to `clk`. They also assume that the parameters satisfy `SERR_MIN` < `DFLT_DLY` and `VS_WIDTH` <= `HOLDOFF`, with `HOLDOFF` of at least 2. The pulse-width and spacing checks are only meaningful under these orderings. The bench drives `csync_n` and `sync_lost` only on falling clock edges, with thresholds of 8, 20, 12 and 200 clocks. Every swept low run is preceded by a high gap longer than the hold-off, so each case starts from an idle detector.

// File: rtl/vsx_pkg.sv
package vsx_pkg;

  // Bits needed to hold the values 0..maxval (never less than one).
  function automatic int cnt_bits(input int maxval);
    return (maxval < 2) ? 1 : $clog2(maxval + 1);
  endfunction

endpackage

// File: rtl/vsx_sync2.sv
module vsx_sync2 #(
  parameter logic IDLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= IDLE;
      sync_q <= IDLE;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/vsx_lowrun.sv
module vsx_lowrun #(
  parameter int SERR_MIN = 429,
  parameter int DFLT_DLY = 1674
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s,          // synchronized sync level, active low
  output logic ser_trig,   // rise ending a serration-class low run
  output logic to_trig     // low run reached the default delay
);

  localparam int LW = vsx_pkg::cnt_bits(DFLT_DLY);
  localparam logic [LW-1:0] L_SAT = LW'(DFLT_DLY);
  localparam logic [LW-1:0] L_TO  = LW'(DFLT_DLY - 1);
  localparam logic [LW-1:0] L_SER = LW'(SERR_MIN);

  logic          s_d;
  logic [LW-1:0] run_q;
  logic [LW-1:0] run_d;
  logic          run_en;

  // Next-state: count low samples, saturate at the timeout value.
  always_comb begin
    run_en = !s && (run_q != L_SAT);
    if (s)
      run_d = '0;
    else if (run_en)
      run_d = run_q + LW'(1);
    else
      run_d = run_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_d   <= 1'b1;
      run_q <= '0;
    end else begin
      s_d   <= s;
      run_q <= run_d;
    end
  end

  assign ser_trig = s && !s_d && (run_q > L_SER);
  assign to_trig  = !s && (run_q == L_TO);

endmodule

// File: rtl/vsx_pulse.sv
module vsx_pulse #(
  parameter int VS_WIDTH = 6210,
  parameter int HOLDOFF  = 224796
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic lost,
  output logic vsync_n
);

  localparam int WW = vsx_pkg::cnt_bits(VS_WIDTH);
  localparam int HW = vsx_pkg::cnt_bits(HOLDOFF);
  localparam logic [WW-1:0] W_LD = WW'(VS_WIDTH);
  localparam logic [HW-1:0] H_LD = HW'(HOLDOFF - 1);

  logic [WW-1:0] wid_q, wid_d;
  logic [HW-1:0] hold_q, hold_d;
  logic          vs_q, vs_d;
  logic          accept;
  logic          wid_en, hold_en;

  always_comb begin
    accept  = trig && !lost && (hold_q == '0);
    wid_en  = (wid_q != '0);
    hold_en = (hold_q != '0);
    if (lost) begin
      wid_d  = '0;
      hold_d = '0;
    end else if (accept) begin
      wid_d  = W_LD;
      hold_d = H_LD;
    end else begin
      wid_d  = wid_en  ? wid_q  - WW'(1) : wid_q;
      hold_d = hold_en ? hold_q - HW'(1) : hold_q;
    end
    vs_d = !(lost || (wid_d != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wid_q  <= '0;
      hold_q <= '0;
      vs_q   <= 1'b1;
    end else begin
      wid_q  <= wid_d;
      hold_q <= hold_d;
      vs_q   <= vs_d;
    end
  end

  assign vsync_n = vs_q;

endmodule

// File: rtl/vsync_extract.sv
module vsync_extract #(
  parameter int SERR_MIN = 429,
  parameter int DFLT_DLY = 1674,
  parameter int VS_WIDTH = 6210,
  parameter int HOLDOFF  = 224796
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_n,
  input  logic sync_lost,
  output logic vsync_n
);

  logic s_sync;
  logic ser_trig;
  logic to_trig;
  logic any_trig;

  vsx_sync2 #(.IDLE(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (csync_n),
    .q     (s_sync)
  );

  vsx_lowrun #(.SERR_MIN(SERR_MIN), .DFLT_DLY(DFLT_DLY)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .s        (s_sync),
    .ser_trig (ser_trig),
    .to_trig  (to_trig)
  );

  assign any_trig = ser_trig || to_trig;

  vsx_pulse #(.VS_WIDTH(VS_WIDTH), .HOLDOFF(HOLDOFF)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n),
    .trig    (any_trig),
    .lost    (sync_lost),
    .vsync_n (vsync_n)
  );

endmodule

// File: rtl/vsx_checker.sv
module vsx_checker #(
  parameter int VS_WIDTH = 6210,
  parameter int HOLDOFF  = 224796
) (
  input logic clk,
  input logic rst_n,
  input logic csync_n,
  input logic sync_lost,
  input logic vsync_n
);

  localparam int CW = vsx_pkg::cnt_bits(VS_WIDTH + 1);
  localparam int GW = vsx_pkg::cnt_bits(HOLDOFF);
  localparam logic [CW-1:0] C_MAX = CW'(VS_WIDTH + 1);
  localparam logic [GW-1:0] G_MAX = GW'(HOLDOFF);

  logic          vs_q;
  logic          lost_q;
  logic          taint_q;
  logic          armed_q;
  logic [CW-1:0] lowcnt_q;
  logic [GW-1:0] gap_q;
  logic          start_ev;
  logic          end_ev;

  assign start_ev = vs_q && !vsync_n && !lost_q;
  assign end_ev   = !vs_q && vsync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q     <= 1'b1;
      lost_q   <= 1'b0;
      taint_q  <= 1'b0;
      armed_q  <= 1'b0;
      lowcnt_q <= '0;
      gap_q    <= '0;
    end else begin
      vs_q   <= vsync_n;
      lost_q <= sync_lost;
      if (sync_lost)
        taint_q <= 1'b1;
      else if (vsync_n)
        taint_q <= 1'b0;
      if (vsync_n)
        lowcnt_q <= '0;
      else if (lowcnt_q != C_MAX)
        lowcnt_q <= lowcnt_q + CW'(1);
      if (sync_lost)
        armed_q <= 1'b0;
      else if (start_ev)
        armed_q <= 1'b1;
      if (start_ev)
        gap_q <= GW'(1);
      else if (gap_q != G_MAX)
        gap_q <= gap_q + GW'(1);
    end
  end

  // R7: loss of sync forces the output low on the next edge
  p_los_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |=> !vsync_n);

  // R5: an undisturbed pulse lasts exactly VS_WIDTH clocks
  p_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (end_ev && !taint_q) |-> (lowcnt_q == CW'(VS_WIDTH)));

  // R6: pulse starts are at least HOLDOFF clocks apart
  p_holdoff_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && armed_q) |-> (gap_q >= GW'(HOLDOFF - 1)));

  // R2 / R4: a pulse start is preceded by a low sync sample
  p_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(vsync_n) && !$past(sync_lost)) |->
      (!$past(csync_n, 3) || !$past(csync_n, 4)));

endmodule

bind vsync_extract vsx_checker #(.VS_WIDTH(VS_WIDTH), .HOLDOFF(HOLDOFF)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .csync_n   (csync_n),
  .sync_lost (sync_lost),
  .vsync_n   (vsync_n)
);

// File: tb/sim_vsync_extract.sv
module sim_vsync_extract;

  localparam int SM = 8;
  localparam int DD = 20;
  localparam int VW = 12;
  localparam int HO = 200;

  logic clk = 1'b0;
  logic rst_n;
  logic csync_n;
  logic sync_lost;
  logic vsync_n;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int nfalls = 0;
  int last_fall = -1;
  int last_width = -1;
  int run_len = 0;
  logic prev_vs = 1'b1;
  int t_set = 0;

  always #10 clk = ~clk;

  vsync_extract #(.SERR_MIN(SM), .DFLT_DLY(DD), .VS_WIDTH(VW), .HOLDOFF(HO)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .csync_n   (csync_n),
    .sync_lost (sync_lost),
    .vsync_n   (vsync_n)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      prev_vs = 1'b1;
      run_len = 0;
    end else begin
      if (prev_vs && !vsync_n) begin
        nfalls++;
        last_fall = cyc;
        run_len = 1;
      end else if (!vsync_n) begin
        run_len++;
      end
      if (vsync_n && !prev_vs) last_width = run_len;
      prev_vs = vsync_n;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    @(negedge clk);
    csync_n = v;
    t_set = cyc;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int f0, tl, tr;
    rst_n = 1'b0;
    csync_n = 1'b1;
    sync_lost = 1'b0;
    repeat (3) @(negedge clk);
    settle();
    chk("R1 reset level", int'(vsync_n), 1);
    @(negedge clk);
    rst_n = 1'b1;
    hold(1'b1, 30);
    settle();
    chk("R1 idle after reset", nfalls, 0);

    // Sweep of single low runs
    for (int n = 1; n <= 30; n++) begin
      hold(1'b1, 250);
      f0 = nfalls;
      hold(1'b0, n);
      tl = t_set;
      hold(1'b1, 60);
      tr = t_set;
      settle();
      if (n <= SM) begin
        chk("R3 short low ignored", nfalls - f0, 0);
      end else if (n < DD) begin
        chk("R2 serration pulse count", nfalls - f0, 1);
        chk("R2 serration fall time", last_fall, tr + 3);
        chk("R5 width serration", last_width, VW);
      end else begin
        chk("R4 timeout pulse count", nfalls - f0, 1);
        chk("R4 timeout fall time", last_fall, tl + DD + 2);
        chk("R5 width timeout", last_width, VW);
      end
    end

    // R8: one very long low run
    hold(1'b1, 250);
    f0 = nfalls;
    hold(1'b0, 150);
    tl = t_set;
    hold(1'b1, 100);
    settle();
    chk("R8 long low single pulse", nfalls - f0, 1);
    chk("R8 long low fall time", last_fall, tl + DD + 2);

    // R6: second trigger one clock inside the hold-off
    hold(1'b1, 250);
    f0 = nfalls;
    hold(1'b0, 10);
    hold(1'b1, HO - 11);
    hold(1'b0, 10);
    hold(1'b1, 60);
    settle();
    chk("R6 retrigger inside hold-off", nfalls - f0, 1);

    // R6: second trigger exactly at the hold-off boundary
    hold(1'b1, 250);
    f0 = nfalls;
    hold(1'b0, 10);
    hold(1'b1, HO - 10);
    hold(1'b0, 10);
    hold(1'b1, 60);
    tr = t_set;
    settle();
    chk("R6 retrigger at hold-off", nfalls - f0, 2);
    chk("R6 second fall time", last_fall, tr + 3);

    // R3: line sync only
    hold(1'b1, 250);
    f0 = nfalls;
    for (int k = 0; k < 20; k++) begin
      hold(1'b0, 3);
      hold(1'b1, 29);
    end
    settle();
    chk("R3 line sync no pulse", nfalls - f0, 0);

    // R9: standard vertical interval
    hold(1'b1, 250);
    f0 = nfalls;
    tr = -1;
    for (int k = 0; k < 6; k++) begin hold(1'b0, 2); hold(1'b1, 14); end
    for (int k = 0; k < 6; k++) begin
      hold(1'b0, 13);
      hold(1'b1, 3);
      if (tr < 0) tr = t_set;
    end
    for (int k = 0; k < 6; k++) begin hold(1'b0, 2); hold(1'b1, 14); end
    for (int k = 0; k < 10; k++) begin hold(1'b0, 3); hold(1'b1, 29); end
    settle();
    chk("R9 one pulse per interval", nfalls - f0, 1);
    chk("R9 starts at first serration", last_fall, tr + 3);

    // R7: loss of sync
    hold(1'b1, 250);
    @(negedge clk);
    sync_lost = 1'b1;
    @(negedge clk);
    settle();
    chk("R7 forced low", int'(vsync_n), 0);
    f0 = nfalls;
    hold(1'b0, 12);
    hold(1'b1, 20);
    settle();
    chk("R7 held low during loss", int'(vsync_n), 0);
    chk("R7 trigger dropped", nfalls - f0, 0);
    @(negedge clk);
    sync_lost = 1'b0;
    @(negedge clk);
    settle();
    chk("R7 released high", int'(vsync_n), 1);
    f0 = nfalls;
    hold(1'b1, 30);
    settle();
    chk("R7 no deferred pulse", nfalls - f0, 0);
    hold(1'b0, 12);
    hold(1'b1, 30);
    tr = t_set;
    settle();
    chk("R7 hold-off cleared", nfalls - f0, 1);
    chk("R7 fall time after loss", last_fall, tr + 3);

    // R1: asynchronous reset during a pulse
    hold(1'b1, 250);
    hold(1'b0, 25);
    settle();
    chk("R4 pulse active before reset", int'(vsync_n), 0);
    #3;
    rst_n = 1'b0;
    #1;
    chk("R1 async reset mid-pulse", int'(vsync_n), 1);
    @(negedge clk);
    csync_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    f0 = nfalls;
    hold(1'b1, 40);
    settle();
    chk("R1 quiet after second reset", nfalls - f0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule